// File: doc/BRIEF.md
# Embedded-Select I2C Register Slave

This block is a two-wire serial slave that exposes a bank of eight small system registers. It has no separate subaddress phase. The upper three bits of every byte the master writes name the target register, and the lower five bits are stored into that register. A transfer may carry any number of such bytes, so several registers can be updated between one START and one STOP.

Reading returns one byte per register. Each byte carries the register number in its upper three bits and the register contents in its lower five. A read always begins at the first register and steps through the bank, wrapping back to the start after the eighth. Two of the registers are status registers whose low bits come live from fault inputs. Writes cannot change them.

The bus lines are oversampled on the system clock through two-flop synchronizers and a stability filter. The block drives SDA only as an open-drain pull-down enable. It does not acknowledge anything while its supply-good input is low.

Top module: `sysreg_i2c_slave`

## Requirements
- R1: An address byte whose upper six bits are 000100 (bit 0 is read=1/write=0, bit 1 is don't-care) is acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged, and the bytes that follow it in the same transfer are ignored.
- R2: While `pwr_ok` is low, no address byte and no data byte is acknowledged, and a data byte received then does not change any register.
- R3: In a write transfer, each data byte is acknowledged. Its bits [7:5] select register n (0 to 7), and its bits [4:0] are stored in that register and appear on `cfg_o[5n+4:5n]`. Any number of bytes may follow one address.
- R4: Registers 0 and 4 are read-only status. Writes selecting them change nothing. When read, register 0 returns `stat_a_i[4:0]` in bits [4:0], and register 4 returns {0, `stat_b_i[3:0]`}. Their `cfg_o` slots stay zero.
- R5: A read returns bytes {n[2:0], contents[4:0]}, MSB first, for n = 0, 1, 2 and so on. The register number advances after each master ACK and wraps from 7 to 0. A master NACK ends the transfer with SDA released.
- R6: After a synchronous active-low reset, all register contents are zero and SDA is released.
- R7: A START (SDA falls while SCL is high) seen at any point, including mid-byte, abandons the current byte and restarts address reception. After a STOP (SDA rises while SCL is high), bits clocked without a new START are ignored.
- R8: The block changes its SDA drive only while the filtered SCL is low.
- R9: A pulse on SCL or SDA that is shorter than `FILT_LEN` system clocks is rejected and does not shift a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain drive) |
| pwr_ok | input | 1 | Supply good; acknowledges are withheld while low |
| stat_a_i | input | 5 | Fault flags shown in register 0 |
| stat_b_i | input | 4 | Fault flags shown in register 4 |
| cfg_o | output | 40 | Stored contents of registers 0..7, 5 bits each, register n at [5n+4:5n] |

## Verification
The embedded assertions check the following on every cycle:
- SDA drive moves only while the filtered SCL is low.
- An acknowledge is raised only when supply-good was high.
- The block is silent when idle and returns to address reception after every START.
- A written payload lands in the selected slot, and writes to the status slots leave the outputs untouched.
- A filtered line changes only after its input has held the new level.

Only the bench's scenarios can show the end-to-end behaviour:
- address matching and rejection;
- the order, content and wrap of read-back bytes, including live status values;
- that a mid-byte START or clocks after a STOP write nothing;
- that a one-cycle SCL spike leaves a byte intact.

// File: rtl/sysreg_pkg.sv
// Shared constants and types for the embedded-select register slave.
// Assumes eight registers of five payload bits and three select bits per byte.
package sysreg_pkg;
    localparam int BYTE_W    = 8;
    localparam int SEL_W     = 3;
    localparam int PAY_W     = BYTE_W - SEL_W;
    localparam int REG_COUNT = 1 << SEL_W;
    localparam logic [SEL_W-1:0] STAT_A_IDX = 3'd0;
    localparam logic [SEL_W-1:0] STAT_B_IDX = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WRITE,
        ST_READ
    } xfer_state_t;
endpackage

// File: rtl/sysreg_line_filter.sv
// Two-flop synchronizer plus stability filter for one open-drain bus line.
// The output follows the input only after FILT_LEN consecutive samples differ
// from it, so shorter spikes are dropped. Resets to the idle-high level.
module sysreg_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Synchronize the raw line and accept a new level once it has held long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == line_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                line_o <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R9: a change of the filtered level was preceded by at least two samples at that level.
    p_glitch_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> ($past(sync_q[1], 1) == line_o && $past(sync_q[1], 2) == line_o));
endmodule

// File: rtl/sysreg_bus_events.sv
// Edge and condition detector on the filtered bus lines.
// Produces one-cycle pulses for SCL rise/fall, START and STOP.
// Assumes both inputs are already synchronous to clk.
module sysreg_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, sda_q;

    // Remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Decode edges and bus conditions from previous versus current levels.
    always_comb begin
        scl_rise = !scl_q && scl_f;
        scl_fall = scl_q && !scl_f;
        start_ev = scl_q && scl_f && sda_q && !sda_f;
        stop_ev  = scl_q && scl_f && !sda_q && sda_f;
    end
endmodule

// File: rtl/sysreg_xfer_fsm.sv
// Byte-level transfer engine: address match, write bytes, read bytes, ACK.
// Samples SDA on SCL rise and updates its SDA drive on SCL fall.
// Assumes event pulses from sysreg_bus_events and a combinational read port.
module sysreg_xfer_fsm
    import sysreg_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b000100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_ev,
    input  logic                stop_ev,
    input  logic                sda_f,
    input  logic                pwr_ok,
    input  logic [BYTE_W-1:0]   rd_byte,
    output logic [SEL_W-1:0]    rd_idx,
    output logic                wr_en,
    output logic [BYTE_W-1:0]   wr_byte,
    output logic                sda_oe
);
    xfer_state_t        state_q;
    logic [3:0]         bcnt_q;
    logic [BYTE_W-1:0]  rx_q;
    logic [BYTE_W-1:0]  tx_q;
    logic               in_ack_q;
    logic               mack_n_q;
    logic [SEL_W-1:0]   ptr_q;

    // Next register to be read is one past the last one sent.
    assign rd_idx = ptr_q + 1'b1;

    // Transfer sequencing: START/STOP handling, bit shifting and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bcnt_q   <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            in_ack_q <= 1'b0;
            mack_n_q <= 1'b1;
            ptr_q    <= '1;
            wr_en    <= 1'b0;
            wr_byte  <= '0;
            sda_oe   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev) begin
                state_q  <= ST_ADDR;
                bcnt_q   <= '0;
                in_ack_q <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (stop_ev) begin
                state_q  <= ST_IDLE;
                in_ack_q <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (state_q != ST_IDLE) begin
                if (scl_rise) begin
                    if (bcnt_q == 4'd8) begin
                        bcnt_q   <= '0;
                        mack_n_q <= sda_f;
                    end else begin
                        bcnt_q <= bcnt_q + 1'b1;
                        rx_q   <= {rx_q[BYTE_W-2:0], sda_f};
                    end
                end else if (scl_fall) begin
                    if (in_ack_q) begin
                        in_ack_q <= 1'b0;
                        if (state_q == ST_READ && !mack_n_q) begin
                            tx_q   <= {rd_byte[BYTE_W-2:0], 1'b0};
                            ptr_q  <= rd_idx;
                            sda_oe <= !rd_byte[BYTE_W-1];
                        end else if (state_q == ST_READ) begin
                            state_q <= ST_IDLE;
                            sda_oe  <= 1'b0;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end else if (bcnt_q == 4'd8) begin
                        case (state_q)
                            ST_ADDR: begin
                                if (rx_q[7:2] == ADDR_HI && pwr_ok) begin
                                    in_ack_q <= 1'b1;
                                    sda_oe   <= 1'b1;
                                    state_q  <= rx_q[0] ? ST_READ : ST_WRITE;
                                    ptr_q    <= '1;
                                    mack_n_q <= 1'b0;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end
                            ST_WRITE: begin
                                if (pwr_ok) begin
                                    in_ack_q <= 1'b1;
                                    sda_oe   <= 1'b1;
                                    wr_en    <= 1'b1;
                                    wr_byte  <= rx_q;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end
                            default: begin
                                in_ack_q <= 1'b1;
                                sda_oe   <= 1'b0;
                            end
                        endcase
                    end else if (state_q == ST_READ) begin
                        tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                        sda_oe <= !tx_q[BYTE_W-1];
                    end
                end
            end
        end
    end

    // R2: the slave acknowledge is only raised when supply-good was high.
    p_ack_needs_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && in_ack_q) |-> $past(pwr_ok));
    // R7: an idle slave never pulls SDA.
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe);
    // R7: a START always restarts address reception from bit zero.
    p_start_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state_q == ST_ADDR && bcnt_q == 4'd0 && !sda_oe));
    // R3: at most one register write per received byte.
    p_one_write_per_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/sysreg_reg_bank.sv
// Eight five-bit registers written by select-tagged bytes, with a read port
// that returns {select, payload}. Slots STAT_A_IDX and STAT_B_IDX are
// read-only and reflect live status inputs (assumed synchronous to clk).
module sysreg_reg_bank
    import sysreg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [BYTE_W-1:0]         wr_byte,
    input  logic [SEL_W-1:0]          rd_idx,
    input  logic [PAY_W-1:0]          stat_a_i,
    input  logic [PAY_W-2:0]          stat_b_i,
    output logic [BYTE_W-1:0]         rd_byte,
    output logic [REG_COUNT*PAY_W-1:0] cfg_o
);
    logic [SEL_W-1:0] wr_sel;
    logic [PAY_W-1:0] rd_pay;

    assign wr_sel = wr_byte[BYTE_W-1 -: SEL_W];

    for (genvar gr = 0; gr < REG_COUNT; gr++) begin : g_slot
        if (SEL_W'(gr) == STAT_A_IDX || SEL_W'(gr) == STAT_B_IDX) begin : g_ro
            assign cfg_o[gr*PAY_W +: PAY_W] = '0;
        end else begin : g_rw
            logic [PAY_W-1:0] q;
            // Store the payload when a byte selects this slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && wr_sel == SEL_W'(gr)) begin
                    q <= wr_byte[PAY_W-1:0];
                end
            end
            assign cfg_o[gr*PAY_W +: PAY_W] = q;
        end
    end

    // Read mux: status slots show live flags, others their stored payload.
    always_comb begin
        if (rd_idx == STAT_A_IDX) begin
            rd_pay = stat_a_i;
        end else if (rd_idx == STAT_B_IDX) begin
            rd_pay = {1'b0, stat_b_i};
        end else begin
            rd_pay = cfg_o[rd_idx*PAY_W +: PAY_W];
        end
        rd_byte = {rd_idx, rd_pay};
    end

    // R3: a write to a writable slot shows up in that slot one cycle later.
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != STAT_A_IDX && wr_sel != STAT_B_IDX)
        |=> cfg_o[$past(wr_sel)*PAY_W +: PAY_W] == $past(wr_byte[PAY_W-1:0]));
    // R4: a write to a status slot leaves every output slot unchanged.
    p_status_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == STAT_A_IDX || wr_sel == STAT_B_IDX)) |=> $stable(cfg_o));
endmodule

// File: rtl/sysreg_i2c_slave.sv
// Top of the embedded-select register slave: line filters, bus event decode,
// transfer engine and register bank. Assumes clk is at least ~20x the SCL rate
// so that the filter latency fits inside the SCL low phase.
module sysreg_i2c_slave
    import sysreg_pkg::*;
#(
    parameter int         FILT_LEN = 3,
    parameter logic [5:0] ADDR_HI  = 6'b000100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scl_i,
    input  logic         sda_i,
    output logic         sda_oe,
    input  logic         pwr_ok,
    input  logic [4:0]   stat_a_i,
    input  logic [3:0]   stat_b_i,
    output logic [39:0]  cfg_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic [SEL_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_byte, wr_byte;
    logic              wr_en;

    assign raw_lines = {scl_i, sda_i};
    assign sda_f     = filt_lines[0];
    assign scl_f     = filt_lines[1];

    for (genvar gl = 0; gl < NLINES; gl++) begin : g_filt
        sysreg_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[gl]),
            .line_o (filt_lines[gl])
        );
    end

    sysreg_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    sysreg_xfer_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_f    (sda_f),
        .pwr_ok   (pwr_ok),
        .rd_byte  (rd_byte),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_byte  (wr_byte),
        .sda_oe   (sda_oe)
    );

    sysreg_reg_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_byte  (wr_byte),
        .rd_idx   (rd_idx),
        .stat_a_i (stat_a_i),
        .stat_b_i (stat_b_i),
        .rd_byte  (rd_byte),
        .cfg_o    (cfg_o)
    );

    // R8: the SDA drive only moves while the filtered clock is low.
    p_sda_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);
    // R6: a reset cycle leaves SDA released and all register slots cleared.
    p_reset_quiet_r6: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && cfg_o == '0));
endmodule

// File: tb/sim_sysreg_i2c_slave.sv
// Bench: a bus master model with directed corner cases and seeded random
// transfers, compared against a register model kept in the bench.
module sim_sysreg_i2c_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 12;      // system clocks per quarter SCL period
    localparam int MAX_CYC    = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic pwr_ok = 1'b1;
    logic [4:0] stat_a = 5'd0;
    logic [3:0] stat_b = 4'd0;
    logic sda_oe;
    logic [39:0] cfg_o;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysreg_i2c_slave u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .pwr_ok   (pwr_ok),
        .stat_a_i (stat_a),
        .stat_b_i (stat_b),
        .cfg_o    (cfg_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int r8_viol = 0;
    logic [4:0] exp_pay [8];
    logic prev_oe = 1'b0;

    // R8 monitor: SDA drive must not move while the raw SCL is high.
    always @(posedge clk) begin
        if (rst_n && sda_oe !== prev_oe && scl_m) r8_viol++;
        prev_oe <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int idx);
        logic [4:0] p;
        if (idx == 0)      p = stat_a;
        else if (idx == 4) p = {1'b0, stat_b};
        else               p = exp_pay[idx];
        return {idx[2:0], p};
    endfunction

    function automatic logic [39:0] exp_cfg();
        logic [39:0] v = '0;
        for (int i = 0; i < 8; i++)
            if (i != 0 && i != 4) v[i*5 +: 5] = exp_pay[i];
        return v;
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clock_bit(input bit b, output bit s, input bit glitch);
        sda_m = b;
        if (glitch) begin
            tick(Q/2); scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(Q/2 - 1);
        end else begin
            tick(Q);
        end
        scl_m = 1'b1; tick(Q);
        s = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit acked, input int glitch_bit);
        bit s;
        for (int i = 7; i >= 0; i--) clock_bit(d[i], s, i == glitch_bit);
        clock_bit(1'b1, s, 1'b0);
        acked = !s;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit give_ack);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s, 1'b0);
            d[i] = s;
        end
        clock_bit(!give_ack, s, 1'b0);
    endtask

    task automatic read_and_check(input int nbytes);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(8'h11, ack, -1);
        check(ack, "R1 read address ack", ack, 1);
        for (int k = 0; k < nbytes; k++) begin
            recv_byte(d, k != nbytes - 1);
            if ((k % 8) == 0 || (k % 8) == 4)
                check(d == exp_byte(k % 8), "R4 status byte read", d, exp_byte(k % 8));
            else
                check(d == exp_byte(k % 8), "R5 read byte order", d, exp_byte(k % 8));
        end
        bus_stop();
        check(sda_oe == 1'b0, "R5 released after NACK", sda_oe, 0);
    endtask

    task automatic run_main();
        bit ack;
        bit s;
        logic [7:0] b;
        int nb;
        for (int i = 0; i < 8; i++) exp_pay[i] = 5'd0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        check(sda_oe == 1'b0, "R6 reset sda released", sda_oe, 0);
        check(cfg_o == 40'd0, "R6 reset registers clear", cfg_o, 0);

        // R1/R3: matching address, two data bytes in one transfer.
        bus_start();
        send_byte(8'h12, ack, -1);
        check(ack, "R1 matching address ack", ack, 1);
        send_byte(8'h3F, ack, -1); exp_pay[1] = 5'h1F;
        check(ack, "R3 data byte ack", ack, 1);
        send_byte(8'h45, ack, -1); exp_pay[2] = 5'h05;
        check(ack, "R3 second data byte ack", ack, 1);
        bus_stop();
        check(cfg_o == exp_cfg(), "R3 multi-byte write", cfg_o, exp_cfg());

        // R1: foreign address is not acknowledged and its data is ignored.
        bus_start();
        send_byte(8'h20, ack, -1);
        check(!ack, "R1 foreign address no ack", ack, 0);
        send_byte(8'h6A, ack, -1);
        check(!ack, "R1 data after foreign address no ack", ack, 0);
        bus_stop();
        check(cfg_o == exp_cfg(), "R1 foreign transfer writes nothing", cfg_o, exp_cfg());

        // R2: supply-good low suppresses acknowledge and writes.
        pwr_ok = 1'b0;
        bus_start();
        send_byte(8'h10, ack, -1);
        check(!ack, "R2 no address ack without power", ack, 0);
        bus_stop();
        pwr_ok = 1'b1;
        bus_start();
        send_byte(8'h10, ack, -1);
        check(ack, "R2 address ack with power", ack, 1);
        pwr_ok = 1'b0;
        send_byte(8'h7E, ack, -1);
        check(!ack, "R2 no data ack without power", ack, 0);
        bus_stop();
        pwr_ok = 1'b1;
        check(cfg_o == exp_cfg(), "R2 unpowered byte not written", cfg_o, exp_cfg());

        // R4: writes to status slots change nothing; read-back shows live flags.
        stat_a = 5'h15; stat_b = 4'hA;
        bus_start();
        send_byte(8'h10, ack, -1);
        send_byte(8'h1F, ack, -1);
        check(ack, "R4 status write still acked", ack, 1);
        send_byte(8'h8F, ack, -1);
        bus_stop();
        check(cfg_o == exp_cfg(), "R4 status writes ignored", cfg_o, exp_cfg());

        // R5: read wraps from register 7 back to 0.
        read_and_check(10);

        // R7: START in the middle of a byte restarts address reception.
        bus_start();
        send_byte(8'h10, ack, -1);
        for (int i = 0; i < 4; i++) clock_bit(1'b1, s, 1'b0);
        bus_start();
        send_byte(8'h10, ack, -1);
        check(ack, "R7 address after mid-byte START", ack, 1);
        send_byte(8'h2A, ack, -1); exp_pay[1] = 5'h0A;
        check(ack, "R7 data after restart ack", ack, 1);
        bus_stop();
        check(cfg_o == exp_cfg(), "R7 restart write result", cfg_o, exp_cfg());

        // R7: bits after STOP without a START are ignored.
        send_byte(8'hBF, ack, -1);
        check(!ack, "R7 no ack after STOP", ack, 0);
        bus_stop();
        check(cfg_o == exp_cfg(), "R7 no write after STOP", cfg_o, exp_cfg());

        // R9: a one-cycle SCL spike inside a low phase does not shift a bit.
        bus_start();
        send_byte(8'h10, ack, -1);
        send_byte(8'hD3, ack, 3); exp_pay[6] = 5'h13;
        check(ack, "R9 byte with spike acked", ack, 1);
        bus_stop();
        check(cfg_o == exp_cfg(), "R9 spike rejected", cfg_o, exp_cfg());

        // Seeded random writes and reads against the bench model (R3, R5).
        for (int it = 0; it < 22; it++) begin
            if ($urandom % 2) begin
                nb = 1 + ($urandom % 4);
                bus_start();
                send_byte(8'h10 | 8'($urandom % 4 & 2), ack, -1);
                for (int k = 0; k < nb; k++) begin
                    b = 8'($urandom);
                    send_byte(b, ack, -1);
                    check(ack, "R3 random byte ack", ack, 1);
                    if (b[7:5] != 3'd0 && b[7:5] != 3'd4) exp_pay[b[7:5]] = b[4:0];
                end
                bus_stop();
                check(cfg_o == exp_cfg(), "R3 random write result", cfg_o, exp_cfg());
            end else begin
                stat_a = 5'($urandom);
                stat_b = 4'($urandom);
                read_and_check(1 + ($urandom % 9));
            end
        end

        check(r8_viol == 0, "R8 SDA moved while SCL high", r8_viol, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        fork
            run_main();
            begin
                repeat (MAX_CYC) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired (R1..) actual=%0d expected=0", MAX_CYC);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule